// File: doc/BRIEF.md
# Serial Configuration Stream Receiver

This block accepts a serial configuration stream, one bit for each clock edge on which the bit-valid qualifier is high. It waits in a hunt state, ignoring ones, until the preamble code `0010` appears. It then reads a 24-bit length count and a fixed 4-bit trailer. After that it takes in a compile-time number of data frames. Each frame is a zero start bit, a payload of parameterised width, and a 4-bit check field.

Each frame whose check field matches the expected pattern is presented on a parallel output with a one-cycle strobe. A mismatch, or a malformed header or start bit, stops the load. The block then pulls an active-low error flag and holds it until reset. Once all of its own frames are in, the downstream data output repeats the incoming data bit, so the rest of the stream reaches the next device in a chain. A completion flag rises when the number of bits counted after the length field equals the received length count.

Top module: `cfg_stream_rx`

## Requirements
- R1: In the hunt state, ones are ignored. The header starts once the last four accepted bits read `0010`, oldest first. Bits presented while `bit_vld` is low have no effect in any state.
- R2: The 24 bits after the preamble are the length count, most significant bit first. They must be followed by the trailer `1111`; any other trailer value is an error.
- R3: Every frame starts with a 0 bit (a 1 there is an error), then FRAME_BITS payload bits most significant first, then 4 check bits most significant first.
- R4: When a frame's 4 check bits equal CHECK_PAT, `frame_vld` is high for exactly one cycle, in the cycle after the last check bit is accepted, and `frame_data` then holds that frame's payload.
- R5: A check mismatch, a bad trailer or a bad start bit drives `err_n` low. It stays low until reset; while it is low no `frame_vld` pulse occurs and `done` does not rise.
- R6: `dout` is 1 until the last check bit of frame FRAMES has been accepted. From the next cycle on, `dout` equals `din` in the same cycle.
- R7: Bits accepted from the first trailer bit onward are counted. `done` rises in the cycle after the counted total equals the length count, and stays high until reset.
- R8: A synchronous reset returns the block to the hunt state with `err_n` = 1, `done` = 0, `frame_vld` = 0 and `dout` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge samples `din` |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Qualifies `din` as a stream bit on this edge |
| din | input | 1 | Serial stream data bit |
| frame_vld | output | 1 | One-cycle strobe for an accepted frame |
| frame_data | output | FRAME_BITS | Payload of the most recent accepted frame |
| err_n | output | 1 | Active-low sticky frame or header error flag |
| done | output | 1 | Length count reached |
| dout | output | 1 | Downstream data: 1 while loading, then `din` |

## Verification
The hardest case to reach from the ports is the exact cycle in which `done` rises. It depends on the length count agreeing with the count of bits after the header, while idle cycles with noisy `din` are interleaved. The bench computes the length from the frame geometry plus a random tail. It checks `done` low before the final counted bit and high right after it. Random start positions, payloads and idle gaps come from a seeded `$urandom`. Directed streams corrupt a check field, the trailer or a start bit at a chosen frame.

// File: rtl/cfg_stream_rx_pkg.sv
package cfg_stream_rx_pkg;
    localparam int          LEN_W     = 24;
    localparam int          FIELD_W   = 4;
    localparam logic [3:0]  PREAMBLE  = 4'b0010;
    localparam logic [3:0]  LEN_TRAIL = 4'b1111;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_TRAIL,
        ST_START,
        ST_DATA,
        ST_CHK,
        ST_PASS,
        ST_ERR
    } rx_state_e;
endpackage

// File: rtl/cfg_stream_rx_sync.sv
// Preamble hunter: a 4-bit window that is refilled with ones while disarmed.
module cfg_stream_rx_sync #(
    parameter logic [3:0] PATTERN = 4'b0010
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic bit_vld,
    input  logic din,
    output logic hit
);
    logic [3:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        hit   = 1'b0;
        if (!arm) begin
            win_d = 4'hF;
        end else if (bit_vld) begin
            win_d = {win_q[2:0], din};
            hit   = (win_d == PATTERN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= 4'hF;
        else     win_q <= win_d;
    end
endmodule

// File: rtl/cfg_stream_rx_len.sv
// Running bit counter compared against the received length count.
module cfg_stream_rx_len #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_val,
    input  logic             count_en,
    output logic             done
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] run;
        logic             done;
    } len_st_t;

    len_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.len  = len_val;
            st_d.run  = '0;
            st_d.done = 1'b0;
        end else if (count_en && !st_q.done) begin
            st_d.run = st_q.run + 1'b1;
            if (st_d.run == st_q.len) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done = st_q.done;
endmodule

// File: rtl/cfg_stream_rx_fsm.sv
// Header, trailer and frame parser.
module cfg_stream_rx_fsm
    import cfg_stream_rx_pkg::*;
#(
    parameter int         FRAMES     = 3,
    parameter int         FRAME_BITS = 8,
    parameter logic [3:0] CHECK_PAT  = 4'b0110
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_vld,
    input  logic                  din,
    input  logic                  pre_hit,
    output logic                  hunt,
    output logic                  len_load,
    output logic [LEN_W-1:0]      len_val,
    output logic                  count_en,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  err_n,
    output logic                  pass
);
    localparam int MAX_RUN = (LEN_W > FRAME_BITS) ? LEN_W : FRAME_BITS;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);
    localparam int FR_W    = $clog2(FRAMES + 1);

    typedef struct packed {
        rx_state_e             state;
        logic [CNT_W-1:0]      cnt;
        logic [FR_W-1:0]       fr_cnt;
        logic [LEN_W-1:0]      len_sr;
        logic [FRAME_BITS-1:0] dat_sr;
        logic [FIELD_W-1:0]    chk_sr;
        logic                  vld;
        logic [FRAME_BITS-1:0] data;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        len_load = 1'b0;
        case (st_q.state)
            ST_HUNT: begin
                if (pre_hit) begin
                    st_d.state = ST_LEN;
                    st_d.cnt   = '0;
                end
            end
            ST_LEN: begin
                if (bit_vld) begin
                    st_d.len_sr = {st_q.len_sr[LEN_W-2:0], din};
                    if (st_q.cnt == CNT_W'(LEN_W - 1)) begin
                        st_d.state = ST_TRAIL;
                        st_d.cnt   = '0;
                        len_load   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (bit_vld) begin
                    st_d.chk_sr = {st_q.chk_sr[FIELD_W-2:0], din};
                    if (st_q.cnt == CNT_W'(FIELD_W - 1)) begin
                        st_d.cnt    = '0;
                        st_d.fr_cnt = '0;
                        st_d.state  = (st_d.chk_sr == LEN_TRAIL) ? ST_START : ST_ERR;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            ST_START: begin
                if (bit_vld) begin
                    st_d.cnt   = '0;
                    st_d.state = din ? ST_ERR : ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_vld) begin
                    st_d.dat_sr = {st_q.dat_sr[FRAME_BITS-2:0], din};
                    if (st_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                        st_d.state = ST_CHK;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            ST_CHK: begin
                if (bit_vld) begin
                    st_d.chk_sr = {st_q.chk_sr[FIELD_W-2:0], din};
                    if (st_q.cnt == CNT_W'(FIELD_W - 1)) begin
                        st_d.cnt = '0;
                        if (st_d.chk_sr == CHECK_PAT) begin
                            st_d.vld    = 1'b1;
                            st_d.data   = st_q.dat_sr;
                            st_d.fr_cnt = st_q.fr_cnt + 1'b1;
                            st_d.state  = (st_q.fr_cnt == FR_W'(FRAMES - 1)) ? ST_PASS : ST_START;
                        end else begin
                            st_d.state = ST_ERR;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            ST_PASS: st_d.state = ST_PASS;
            ST_ERR:  st_d.state = ST_ERR;
            default: st_d.state = ST_ERR;
        endcase
        len_val = st_d.len_sr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.state <= ST_HUNT;
        end else begin
            st_q <= st_d;
        end
    end

    assign hunt       = (st_q.state == ST_HUNT);
    assign pass       = (st_q.state == ST_PASS);
    assign err_n      = (st_q.state != ST_ERR);
    assign frame_vld  = st_q.vld;
    assign frame_data = st_q.data;
    assign count_en   = bit_vld && (st_q.state inside {ST_TRAIL, ST_START, ST_DATA, ST_CHK, ST_PASS});
endmodule

// File: rtl/cfg_stream_rx.sv
module cfg_stream_rx
    import cfg_stream_rx_pkg::*;
#(
    parameter int         FRAMES     = 3,
    parameter int         FRAME_BITS = 8,
    parameter logic [3:0] CHECK_PAT  = 4'b0110
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_vld,
    input  logic                  din,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  err_n,
    output logic                  done,
    output logic                  dout
);
    logic             pre_hit;
    logic             hunt;
    logic             len_load;
    logic [LEN_W-1:0] len_val;
    logic             count_en;
    logic             pass;

    cfg_stream_rx_sync #(.PATTERN(PREAMBLE)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .arm     (hunt),
        .bit_vld (bit_vld),
        .din     (din),
        .hit     (pre_hit)
    );

    cfg_stream_rx_fsm #(
        .FRAMES     (FRAMES),
        .FRAME_BITS (FRAME_BITS),
        .CHECK_PAT  (CHECK_PAT)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (bit_vld),
        .din        (din),
        .pre_hit    (pre_hit),
        .hunt       (hunt),
        .len_load   (len_load),
        .len_val    (len_val),
        .count_en   (count_en),
        .frame_vld  (frame_vld),
        .frame_data (frame_data),
        .err_n      (err_n),
        .pass       (pass)
    );

    cfg_stream_rx_len #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst      (rst),
        .load     (len_load),
        .len_val  (len_val),
        .count_en (count_en),
        .done     (done)
    );

    assign dout = pass ? din : 1'b1;
endmodule

// File: rtl/cfg_stream_rx_chk.sv
module cfg_stream_rx_chk (
    input logic clk,
    input logic rst,
    input logic frame_vld,
    input logic err_n,
    input logic done,
    input logic dout
);
    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst) !err_n |=> !err_n);
    // R5
    no_frame_in_err_chk: assert property (@(posedge clk) disable iff (rst) !err_n |-> !frame_vld);
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst) done |=> done);
    // R4
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst) frame_vld |=> !frame_vld);
    // R6
    dout_idle_in_err_chk: assert property (@(posedge clk) disable iff (rst) !err_n |-> dout);
    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (err_n && !done && !frame_vld));
endmodule

bind cfg_stream_rx cfg_stream_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .err_n     (err_n),
    .done      (done),
    .dout      (dout)
);

// File: tb/cfg_stream_rx_tb.sv
module cfg_stream_rx_tb;
    localparam int         FRAMES = 3;
    localparam int         FB     = 8;
    localparam logic [3:0] CP     = 4'b0110;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_vld = 1'b0;
    logic          din = 1'b1;
    logic          frame_vld;
    logic [FB-1:0] frame_data;
    logic          err_n;
    logic          done;
    logic          dout;

    int     n_checks = 0;
    int     n_errors = 0;
    bit     use_gaps = 1'b0;
    bit     exp_pass = 1'b0;
    int     dout_bad = 0;
    int     rx_cnt   = 0;
    logic [FB-1:0] rx_data [0:7];
    logic [FB-1:0] exp_data [0:7];

    always #5 clk = ~clk;

    cfg_stream_rx #(.FRAMES(FRAMES), .FRAME_BITS(FB), .CHECK_PAT(CP)) u_dut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .din(din),
        .frame_vld(frame_vld), .frame_data(frame_data),
        .err_n(err_n), .done(done), .dout(dout)
    );

    always @(negedge clk) begin
        if (!rst && frame_vld) begin
            if (rx_cnt < 8) rx_data[rx_cnt] = frame_data;
            rx_cnt = rx_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int stream_len(input int tail);
        return 4 + FRAMES * (1 + FB + 4) + 4 + tail;
    endfunction

    task automatic send_bit(input logic b);
        if (use_gaps) begin
            repeat ($urandom % 3) begin
                @(negedge clk);
                bit_vld = 1'b0;
                din = 1'($urandom);
                #1;
                if (dout !== (exp_pass ? din : 1'b1)) dout_bad++;
            end
        end
        @(negedge clk);
        din = b;
        bit_vld = 1'b1;
        #1;
        if (dout !== (exp_pass ? din : 1'b1)) dout_bad++;
    endtask

    task automatic settle();
        @(negedge clk);
        bit_vld = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_pass = 1'b0;
        dout_bad = 0;
        rx_cnt = 0;
        #1;
    endtask

    // bad_trail: corrupt trailer; bad_start / bad_chk: frame index to corrupt (-1 none)
    task automatic run_stream(input int lead, input int tail, input bit bad_trail,
                              input int bad_start, input int bad_chk);
        int   len;
        int   exp_frames;
        bit   good;
        logic [3:0] ck;
        len  = stream_len(tail);
        good = !bad_trail && bad_start < 0 && bad_chk < 0;
        exp_frames = bad_trail ? 0 : (bad_start >= 0) ? bad_start : (bad_chk >= 0) ? bad_chk : FRAMES;
        do_reset();
        for (int i = 0; i < lead; i++) send_bit(1'b1);
        for (int i = 3; i >= 0; i--) send_bit(1'(4'b0010 >> i));
        for (int i = 23; i >= 0; i--) send_bit(1'(len >> i));
        for (int i = 3; i >= 0; i--) send_bit(bad_trail ? 1'(4'b1011 >> i) : 1'b1);
        for (int f = 0; f < FRAMES; f++) begin
            exp_data[f] = FB'($urandom);
            send_bit(f == bad_start ? 1'b1 : 1'b0);
            for (int i = FB - 1; i >= 0; i--) send_bit(exp_data[f][i]);
            ck = (f == bad_chk) ? (CP ^ 4'b0100) : CP;
            for (int i = 3; i >= 0; i--) send_bit(ck[i]);
            if (good && f == FRAMES - 1) exp_pass = 1'b1;
        end
        for (int i = 3; i >= 0; i--) send_bit(1'(4'b0111 >> i));
        for (int i = 0; i < tail - 1; i++) send_bit(1'($urandom));
        settle();
        check("R7 done low before last counted bit", done, 1'b0);
        send_bit(1'($urandom));
        settle();
        check(good ? "R7 done after length reached" : "R5 done stays low on error", done, good);
        for (int i = 0; i < 5; i++) send_bit(1'($urandom));
        settle();
        check("R7 done held", done, good);
        check(good ? "R1 R2 R3 header accepted" : "R5 err_n low", err_n, good);
        check("R4 R5 frame count", rx_cnt, exp_frames);
        for (int f = 0; f < exp_frames && f < 8; f++)
            check("R4 frame payload", rx_data[f], exp_data[f]);
        check("R6 dout tracking", dout_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        check("R8 reset err_n", err_n, 1'b1);
        check("R8 reset done", done, 1'b0);
        check("R8 reset frame_vld", frame_vld, 1'b0);
        check("R8 reset dout", dout, 1'b1);

        // R1 R2 R3 R4 R6 R7 plain streams, no gaps
        run_stream(8, 3, 1'b0, -1, -1);
        use_gaps = 1'b1;
        for (int k = 0; k < 4; k++)
            run_stream(8 + int'($urandom % 12), 1 + int'($urandom % 20), 1'b0, -1, -1);
        // R1 long run of ones in hunt
        run_stream(40, 2, 1'b0, -1, -1);
        // R5 check mismatch on frame 1
        run_stream(9, 4, 1'b0, -1, 1);
        // R2 bad trailer
        run_stream(8, 4, 1'b1, -1, -1);
        // R3 bad start bit on frame 2
        run_stream(10, 4, 1'b0, 2, -1);
        // R8 reset clears error
        do_reset();
        check("R8 reset clears err_n", err_n, 1'b1);
        check("R8 reset clears done", done, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(1_500_000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule